// File: doc/BRIEF.md
# Platform Interrupt Register and Claim Unit

This block is the register side of a platform-level interrupt controller. Each interrupt source line sets a sticky pending bit. Software programs a priority for each source, a set of enable bits for each context and a threshold for each context. A selector then asserts one interrupt output per context while some source is eligible for that context. Software acknowledges an interrupt by reading the context's claim register and reports that service is finished by writing the same ID back to that register.

Accesses arrive on a plain 32-bit register bus that uses a request strobe and a write flag. The data for a read appears on the cycle after the request. At any other time the read data is zero. Region bases and strides are parameters, and each stride must be a power of two.

Top module: `ictl_top`

## Requirements
- R1: An access with a nonzero low address pair (bits 1:0), or to an address outside every region, reads 0 and its write changes no state.
- R2: Source n has a priority word at PRIO_BASE + 4n. A write to the word of source 0 is dropped, so that word always reads 0.
- R3: When PRIO_MAX+1 is a power of two, a write to a priority or threshold word stores the written value modulo PRIO_MAX+1.
- R4: When PRIO_MAX+1 is not a power of two, a write to a priority or threshold word whose value exceeds PRIO_MAX is discarded and the old value remains.
- R5: The pending word at PEND_BASE + 4w holds in bit b the pending state of source 32w+b. The word is read-only, and a write to it has no effect.
- R6: Enable word w of context c is at EN_BASE + c*EN_STRIDE + 4w, and bit b of that word enables source 32w+b. Bits for IDs at or above NSRC read 0. A word index at or above ceil(NSRC/32) reads 0 and ignores writes.
- R7: In the block of context c at CTX_BASE + c*CTX_STRIDE, offset 0 is the threshold and offset 4 is claim/complete. Every other offset reads 0 and ignores writes.
- R8: The selected ID of a context is the source that is pending, not claimed, enabled, and has a priority strictly above the context threshold, with the highest priority winning. A tie goes to the lowest ID. When no source qualifies the ID is 0. irq_o[c] is high exactly when the selected ID is nonzero.
- R9: A claim read returns the selected ID. If that ID is nonzero, the read also clears the source's pending bit and sets its claimed bit.
- R10: A write of an ID below NSRC to any context's claim/complete word clears that source's claimed bit, whatever the enables hold. A larger ID is ignored.
- R11: A high source input sets its pending bit on the next edge. A low input never clears the bit.
- R12: If a claim of a source and a high input for that same source occur in one cycle, the source is still pending afterwards.
- R13: Reset clears every priority, threshold, enable, pending bit and claimed bit, and holds all interrupt outputs and the read data at 0.
- R14: Read data appears on the cycle after the read request. On every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Access request strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| src_i | input | NSRC | Interrupt source lines |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
The main instance uses NSRC=40, NCTX=2 and PRIO_MAX=7. With 40 sources the second bitfield word is only partly used, so the masking of enable and pending bits above the source count can be observed, and an enable word index past the last valid one can be probed. Because PRIO_MAX+1 is a power of two on this instance, priority and threshold writes take the modulo path. A second instance with NSRC=8, NCTX=1 and PRIO_MAX=5 covers the path where an over-range write is discarded. Two contexts with different enables make it possible to show that a complete write ignores the enables, and that a context with nothing enabled claims 0 without side effects.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/ictl_decode.sv
module ictl_decode
    import ictl_pkg::*;
#(
    parameter int          NSRC       = 40,
    parameter int          NCTX       = 2,
    parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
    parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
    parameter logic [31:0] EN_BASE    = 32'h0000_2000,
    parameter int          EN_STRIDE  = 128,
    parameter logic [31:0] CTX_BASE   = 32'h0001_0000,
    parameter int          CTX_STRIDE = 4096,
    parameter int          SW         = 6,
    parameter int          CW         = 1,
    parameter int          WIDX       = 1
) (
    input  logic [31:0]     addr_i,
    output region_e         region_o,
    output logic [SW-1:0]   src_o,
    output logic [CW-1:0]   ctx_o,
    output logic [WIDX-1:0] word_o
);
    localparam int          NWORDS    = (NSRC + 31) / 32;
    localparam int          ESH       = $clog2(EN_STRIDE);
    localparam int          CSH       = $clog2(CTX_STRIDE);
    localparam logic [31:0] PRIO_SPAN = 32'(NSRC * 4);
    localparam logic [31:0] PEND_SPAN = 32'(NWORDS * 4);
    localparam logic [31:0] EN_SPAN   = 32'(NCTX * EN_STRIDE);
    localparam logic [31:0] CTX_SPAN  = 32'(NCTX * CTX_STRIDE);

    logic [31:0] off_p, off_q, off_e, off_c;

    always_comb begin
        off_p    = addr_i - PRIO_BASE;
        off_q    = addr_i - PEND_BASE;
        off_e    = addr_i - EN_BASE;
        off_c    = addr_i - CTX_BASE;
        region_o = RG_NONE;
        src_o    = '0;
        ctx_o    = '0;
        word_o   = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i >= PRIO_BASE && off_p < PRIO_SPAN) begin
                region_o = RG_PRIO;
                src_o    = off_p[SW+1:2];
            end else if (addr_i >= PEND_BASE && off_q < PEND_SPAN) begin
                region_o = RG_PEND;
                word_o   = off_q[WIDX+1:2];
            end else if (addr_i >= EN_BASE && off_e < EN_SPAN) begin
                ctx_o = off_e[ESH+CW-1:ESH];
                if (32'(off_e[ESH-1:2]) < 32'(NWORDS)) begin
                    region_o = RG_EN;
                    word_o   = off_e[WIDX+1:2];
                end
            end else if (addr_i >= CTX_BASE && off_c < CTX_SPAN) begin
                ctx_o = off_c[CSH+CW-1:CSH];
                if (off_c[CSH-1:0] == '0)
                    region_o = RG_THR;
                else if (32'(off_c[CSH-1:0]) == 32'd4)
                    region_o = RG_CLAIM;
            end
        end
    end

endmodule

// File: rtl/ictl_srcstate.sv
module ictl_srcstate #(
    parameter int NSRC = 40,
    parameter int SW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            claim_fire_i,
    input  logic [SW-1:0]   claim_id_i,
    input  logic            done_fire_i,
    input  logic [SW-1:0]   done_id_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] clm_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] clm;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] claim_mask, done_mask;

    always_comb begin
        claim_mask = '0;
        done_mask  = '0;
        if (claim_fire_i) claim_mask[claim_id_i] = 1'b1;
        if (done_fire_i)  done_mask[done_id_i]   = 1'b1;
        st_d      = st_q;
        // new input wins over the claim clear (R12)
        st_d.pend = (st_q.pend & ~claim_mask) | src_i;
        st_d.clm  = (st_q.clm & ~done_mask) | claim_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign clm_o  = st_q.clm;

    a_r11_input_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((pend_o & $past(src_i)) == $past(src_i)));

    a_r9_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire_i |=> clm_o[$past(claim_id_i)]);

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_fire_i && !claim_fire_i) |=> !clm_o[$past(done_id_i)]);

endmodule

// File: rtl/ictl_select.sv
module ictl_select #(
    parameter int NSRC = 40,
    parameter int PW   = 3,
    parameter int SW   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          cand_i,
    input  logic [NSRC-1:0][PW-1:0]  pri_i,
    input  logic [PW-1:0]            thr_i,
    output logic [SW-1:0]            id_o
);
    logic [PW-1:0] best_p;

    always_comb begin
        best_p = thr_i;
        id_o   = '0;
        for (int i = 1; i < NSRC; i++) begin
            if (cand_i[i] && pri_i[i] > best_p) begin
                best_p = pri_i[i];
                id_o   = SW'(i);
            end
        end
    end

    a_r8_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (id_o != '0) |-> (cand_i[id_o] && pri_i[id_o] > thr_i));

endmodule

// File: rtl/ictl_top.sv
module ictl_top
    import ictl_pkg::*;
#(
    parameter int          NSRC       = 40,
    parameter int          NCTX       = 2,
    parameter int          PRIO_MAX   = 7,
    parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
    parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
    parameter logic [31:0] EN_BASE    = 32'h0000_2000,
    parameter int          EN_STRIDE  = 128,
    parameter logic [31:0] CTX_BASE   = 32'h0001_0000,
    parameter int          CTX_STRIDE = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req_i,
    input  logic            bus_wr_i,
    input  logic [31:0]     bus_addr_i,
    input  logic [31:0]     bus_wdata_i,
    output logic [31:0]     bus_rdata_o,
    input  logic [NSRC-1:0] src_i,
    output logic [NCTX-1:0] irq_o
);
    localparam int NWORDS = (NSRC + 31) / 32;
    localparam int PADW   = NWORDS * 32;
    localparam int SW     = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int CW     = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int WIDX   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int PW     = $clog2(PRIO_MAX + 1);
    localparam bit WARL   = is_pow2(PRIO_MAX + 1);

    typedef struct packed {
        logic [NSRC-1:0][PW-1:0] pri;
        logic [NCTX-1:0][PW-1:0] thr;
        logic [NCTX-1:0][NSRC-1:0] en;
        logic [31:0]             rdata;
    } regs_t;

    regs_t r_d, r_q;

    region_e         region;
    logic [SW-1:0]   src_idx;
    logic [CW-1:0]   ctx_idx;
    logic [WIDX-1:0] word_idx;

    logic [NSRC-1:0] pend, clm;
    logic [NCTX-1:0][SW-1:0] sel_id;
    logic            rd_op, wr_op, claim_fire, done_fire, val_ok;
    logic [PW-1:0]   val_st;
    logic [PADW-1:0] pad_rd, pad_wr;

    ictl_decode #(
        .NSRC(NSRC), .NCTX(NCTX), .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
        .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE),
        .CTX_STRIDE(CTX_STRIDE), .SW(SW), .CW(CW), .WIDX(WIDX)
    ) u_dec (
        .addr_i   (bus_addr_i),
        .region_o (region),
        .src_o    (src_idx),
        .ctx_o    (ctx_idx),
        .word_o   (word_idx)
    );

    ictl_srcstate #(.NSRC(NSRC), .SW(SW)) u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .claim_fire_i (claim_fire),
        .claim_id_i   (sel_id[ctx_idx]),
        .done_fire_i  (done_fire),
        .done_id_i    (bus_wdata_i[SW-1:0]),
        .pend_o       (pend),
        .clm_o        (clm)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        ictl_select #(.NSRC(NSRC), .PW(PW), .SW(SW)) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand_i (pend & ~clm & r_q.en[c]),
            .pri_i  (r_q.pri),
            .thr_i  (r_q.thr[c]),
            .id_o   (sel_id[c])
        );
        assign irq_o[c] = (sel_id[c] != '0);
    end

    always_comb begin
        rd_op      = bus_req_i && !bus_wr_i;
        wr_op      = bus_req_i && bus_wr_i;
        claim_fire = rd_op && (region == RG_CLAIM) && (sel_id[ctx_idx] != '0);
        done_fire  = wr_op && (region == RG_CLAIM) && (bus_wdata_i < 32'(NSRC));
        val_ok     = WARL || (bus_wdata_i <= 32'(PRIO_MAX));
        val_st     = bus_wdata_i[PW-1:0];

        pad_rd = '0;
        if (region == RG_PEND) pad_rd[NSRC-1:0] = pend;
        else                   pad_rd[NSRC-1:0] = r_q.en[ctx_idx];
        pad_wr = pad_rd;
        pad_wr[word_idx*32 +: 32] = bus_wdata_i;

        r_d       = r_q;
        r_d.rdata = '0;
        if (rd_op) begin
            unique case (region)
                RG_PRIO:  r_d.rdata = 32'(r_q.pri[src_idx]);
                RG_PEND,
                RG_EN:    r_d.rdata = pad_rd[word_idx*32 +: 32];
                RG_THR:   r_d.rdata = 32'(r_q.thr[ctx_idx]);
                RG_CLAIM: r_d.rdata = 32'(sel_id[ctx_idx]);
                default:  r_d.rdata = '0;
            endcase
        end
        if (wr_op) begin
            unique case (region)
                RG_PRIO: if (src_idx != '0 && val_ok) r_d.pri[src_idx] = val_st;
                RG_THR:  if (val_ok) r_d.thr[ctx_idx] = val_st;
                RG_EN:   r_d.en[ctx_idx] = pad_wr[NSRC-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata_o = r_q.rdata;

    a_r14_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req_i && !bus_wr_i) |=> (bus_rdata_o == '0));

    a_r2_src0_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_wr_i && bus_addr_i == PRIO_BASE) |=> $stable(r_q.pri[0]));

endmodule

// File: tb/ictl_top_test.sv
module ictl_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 40;
    localparam int NC  = 2;
    localparam int PM  = 7;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 0, wr = 0;
    logic [31:0] addr = 0, wdata = 0;
    logic [31:0] rdata;
    logic [NS-1:0] src = '0;
    logic [NC-1:0] irq;

    logic np_req = 0, np_wr = 0;
    logic [31:0] np_addr = 0, np_wdata = 0, np_rdata;
    logic [7:0] np_irq;
    logic [0:0] np_irq_o;

    int vectors = 0, miscmp = 0, cycles = 0;
    bit done = 0;
    string cur_req = "R13";

    always #(CLK_PERIOD/2) clk = ~clk;

    ictl_top #(.NSRC(NS), .NCTX(NC), .PRIO_MAX(PM)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .src_i(src), .irq_o(irq));

    ictl_top #(.NSRC(8), .NCTX(1), .PRIO_MAX(5)) uut_np (
        .clk(clk), .rst_n(rst_n), .bus_req_i(np_req), .bus_wr_i(np_wr),
        .bus_addr_i(np_addr), .bus_wdata_i(np_wdata), .bus_rdata_o(np_rdata),
        .src_i(8'h00), .irq_o(np_irq_o));

    // reference model state
    int m_pri[NS];
    int m_thr[NC];
    bit m_pend[NS];
    bit m_clm[NS];
    bit m_en[NC][NS];
    longint unsigned exp_rd = 0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            miscmp++;
            $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WDOG);
            done = 1;
            summary();
        end
    end

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_sel(int c);
        int best = 0;
        int bp = m_thr[c];
        for (int i = 1; i < NS; i++)
            if (m_pend[i] && !m_clm[i] && m_en[c][i] && m_pri[i] > bp) begin
                best = i;
                bp = m_pri[i];
            end
        return best;
    endfunction

    // kinds: 0 none,1 prio,2 pend,3 en,4 thr,5 claim
    function automatic void m_decode(input int unsigned a, output int kind,
                                     output int idx, output int c);
        kind = 0; idx = 0; c = 0;
        if (a % 4 != 0) return;
        if (a < NS * 4) begin kind = 1; idx = a / 4; end
        else if (a >= 'h1000 && a < 'h1008) begin kind = 2; idx = (a - 'h1000) / 4; end
        else if (a >= 'h2000 && a < 'h2000 + NC * 128) begin
            c = (a - 'h2000) / 128;
            idx = ((a - 'h2000) % 128) / 4;
            if (idx < 2) kind = 3;
        end else if (a >= 'h10000 && a < 'h10000 + NC * 4096) begin
            c = (a - 'h10000) / 4096;
            if ((a - 'h10000) % 4096 == 0) kind = 4;
            else if ((a - 'h10000) % 4096 == 4) kind = 5;
        end
    endfunction

    function automatic longint unsigned bits_word(int w, bit pendsel, int c);
        longint unsigned v = 0;
        for (int b = 0; b < 32; b++) begin
            int id = w * 32 + b;
            if (id < NS) begin
                if (pendsel ? m_pend[id] : m_en[c][id]) v |= (64'd1 << b);
            end
        end
        return v;
    endfunction

    // one cycle: compare outputs, then drive and advance the model
    task automatic step(bit rq, bit we, int unsigned a, int unsigned wd, logic [NS-1:0] s);
        int kind, idx, c, sid;
        longint unsigned nrd = 0;
        @(negedge clk);
        chk({cur_req, " rdata"}, rdata, exp_rd);
        for (int k = 0; k < NC; k++) chk({cur_req, " R8 irq"}, irq[k], m_sel(k) != 0);
        req = rq; wr = we; addr = a; wdata = wd; src = s;
        m_decode(a, kind, idx, c);
        if (rq && !we) begin
            case (kind)
                1: nrd = m_pri[idx];
                2: nrd = bits_word(idx, 1, 0);
                3: nrd = bits_word(idx, 0, c);
                4: nrd = m_thr[c];
                5: begin
                    sid = m_sel(c);
                    nrd = sid;
                    if (sid != 0) begin m_pend[sid] = 0; m_clm[sid] = 1; end
                end
                default: nrd = 0;
            endcase
        end
        if (rq && we) begin
            case (kind)
                1: if (idx != 0) m_pri[idx] = wd % (PM + 1);
                3: for (int b = 0; b < 32; b++)
                       if (idx * 32 + b < NS) m_en[c][idx * 32 + b] = wd[b];
                4: m_thr[c] = wd % (PM + 1);
                5: if (wd < NS) m_clm[wd] = 0;
                default: ;
            endcase
        end
        for (int i = 0; i < NS; i++) if (s[i]) m_pend[i] = 1;
        exp_rd = nrd;
    endtask

    task automatic np_op(bit we, int unsigned a, int unsigned wd, output logic [31:0] rd);
        @(negedge clk);
        np_req = 1; np_wr = we; np_addr = a; np_wdata = wd;
        @(negedge clk);
        np_req = 0; np_wr = 0;
        rd = np_rdata;
    endtask

    localparam int unsigned CT0 = 'h10000;
    localparam int unsigned CT1 = 'h11000;

    initial begin
        logic [31:0] r;
        logic [NS-1:0] z = '0;
        // R13: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R13 rdata", rdata, 0);
            chk("R13 irq", irq, 0);
        end
        rst_n = 1;

        // R4: non-power-of-two priority count discards over-range writes
        np_op(1, 4, 5, r);
        np_op(0, 4, 0, r);  chk("R4 store legal", r, 5);
        np_op(1, 4, 6, r);
        np_op(0, 4, 0, r);  chk("R4 drop 6", r, 5);
        np_op(1, 'h10000, 9, r);
        np_op(0, 'h10000, 0, r); chk("R4 thr drop", r, 0);
        np_op(1, 'h10000, 3, r);
        np_op(0, 'h10000, 0, r); chk("R4 thr legal", r, 3);

        // R2: source 0 priority fixed, others stored
        cur_req = "R2";
        step(1, 1, 0, 5, z);
        step(1, 0, 0, 0, z);
        step(1, 1, 12, 5, z);
        step(1, 0, 12, 0, z);
        // R3: modulo storage
        cur_req = "R3";
        step(1, 1, 16, 13, z);
        step(1, 0, 16, 0, z);
        step(1, 1, 140, 3, z);
        // R11: pulse inputs then release
        cur_req = "R11";
        step(0, 0, 0, 0, (40'd1 << 3) | (40'd1 << 4) | (40'd1 << 35));
        step(0, 0, 0, 0, z);
        // R5: pending read-only
        cur_req = "R5";
        step(1, 0, 'h1000, 0, z);
        step(1, 0, 'h1004, 0, z);
        step(1, 1, 'h1000, 0, z);
        step(1, 0, 'h1000, 0, z);
        // R6: enable words
        cur_req = "R6";
        step(1, 1, 'h2000, 32'hFFFF_FFFF, z);
        step(1, 1, 'h2004, 32'hFFFF_FFFF, z);
        step(1, 0, 'h2004, 0, z);
        step(1, 1, 'h2008, 32'h1234, z);
        step(1, 0, 'h2008, 0, z);
        // R7: threshold and invalid offset
        cur_req = "R7";
        step(1, 1, CT0, 2, z);
        step(1, 0, CT0, 0, z);
        step(1, 1, CT0 + 8, 7, z);
        step(1, 0, CT0 + 8, 0, z);
        // R8/R9: claims with tie on priority 5 (sources 3 and 4)
        cur_req = "R9";
        step(1, 0, CT0 + 4, 0, z);
        step(1, 0, CT1 + 4, 0, z);
        step(1, 0, CT0 + 4, 0, z);
        step(1, 0, CT0 + 4, 0, z);
        // R10: complete from a context without enables, out-of-range id
        cur_req = "R10";
        step(1, 1, CT1 + 4, 3, z);
        step(1, 1, CT1 + 4, 40, z);
        step(0, 0, 0, 0, 40'd1 << 3);
        step(0, 0, 0, 0, z);
        // R12: claim and same-source input in one cycle
        cur_req = "R12";
        step(1, 0, CT0 + 4, 0, 40'd1 << 3);
        step(1, 0, 'h1000, 0, z);
        step(1, 1, CT0 + 4, 3, z);
        step(0, 0, 0, 0, z);
        // R1: unaligned and unmapped
        cur_req = "R1";
        step(1, 0, 'h2001, 0, z);
        step(1, 1, 13, 7, z);
        step(1, 0, 12, 0, z);
        step(1, 1, 'h5000, 7, z);
        step(1, 0, 'h5000, 0, z);
        step(1, 0, 'hFFFF_FFF0, 0, z);
        // R14 and all: random traffic
        cur_req = "R14";
        for (int n = 0; n < 4000; n++) begin
            logic [NS-1:0] s = '0;
            int unsigned a, wd;
            int sel = $urandom % 10;
            bit we = $urandom % 2;
            for (int i = 0; i < NS; i++) s[i] = ($urandom % 24 == 0);
            case (sel)
                0, 1: begin a = ($urandom % NS) * 4; wd = $urandom % 16; end
                2: begin a = 'h1000 + ($urandom % 2) * 4; wd = $urandom; end
                3: begin a = 'h2000 + ($urandom % NC) * 128 + ($urandom % 3) * 4; wd = $urandom; end
                4: begin a = CT0 + ($urandom % NC) * 4096; wd = $urandom % 10; end
                5, 6, 7, 8: begin a = CT0 + ($urandom % NC) * 4096 + 4; wd = $urandom % 44; end
                default: begin a = $urandom; wd = $urandom; end
            endcase
            step($urandom % 4 != 0, we, a, wd, s);
        end
        step(0, 0, 0, 0, z);
        done = 1;
        summary();
    end
endmodule